// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filter

This block recovers asynchronous serial characters from a receive line. It oversamples at 16 or 4 ticks per bit, from a programmable clock divisor. A falling edge on the idle-high line starts a candidate start bit. The block accepts the start bit only if the line is still low at mid-bit. Each data bit, the optional parity bit and the stop bit are then sampled at the centre of their bit periods.

Every finished character is pushed into a four-entry queue, together with its own parity-error and framing-error flags. The consumer reads the oldest word, which is always visible on the output, and pops it with a one-cycle read strobe. A sticky overrun flag records a character that arrived while the queue was full. Reception then halts until software clears the flag. A flow-control output tells the far end to pause once the queue is nearly full.

In 9-bit mode with address filtering enabled, only characters whose ninth bit is set reach the queue. A loopback switch replaces the external line with a local transmit signal for self-test.

The receiver is built around a six-state machine:
- IDLE waits for a low sample.
- START checks the line again at mid-bit. It goes to DATA if the line is low, and back to IDLE if the line is high.
- DATA shifts in the data bits. It goes to PARITY when parity is enabled, and to STOP1 otherwise.
- PARITY captures the parity bit.
- STOP1 samples the first stop bit and emits the word. It goes to STOP2 when two stop bits are configured, and to IDLE otherwise.
- STOP2 waits out the second stop bit and then returns to IDLE.

Top module: `uart_rx_addr`

## Requirements
- R1: After reset, `not_empty` and `overrun` are 0 and `rts_ready` is 1.
- R2: A frame is one low start bit, then 8 data bits (or 9 when `cfg_nine_bit`=1) LSB first, then the stop bit(s), high. One bit lasts (`cfg_div`+1)×16 clocks, or (`cfg_div`+1)×4 clocks when `cfg_quad`=1. In 8-bit mode `rd_data[8]` reads 0.
- R3: A low pulse on the idle line shorter than half a bit produces no word.
- R4: In 8-bit mode a parity bit follows the data: `cfg_parity`=2'b01 selects even and 2'b10 selects odd. With 2'b00, or in 9-bit mode, there is no parity bit. `rd_perr` is 1 exactly when the received parity bit mismatches.
- R5: A first stop bit sampled low still stores the word, with `rd_ferr`=1. When `cfg_two_stop`=1, a second stop bit is awaited before the next start bit is searched for.
- R6: Words are kept in a 4-entry first-in first-out queue. `rd_data`/`rd_perr`/`rd_ferr` show the oldest word, and a cycle with `rd_en`=1 and `not_empty`=1 removes it.
- R7: A character that completes while 4 words are stored sets `overrun` and is discarded. While `overrun` is 1, no new character is received. A one-cycle `ovf_clr` pulse clears the flag.
- R8: With `cfg_nine_bit`=1 and `cfg_addr_en`=1, characters whose bit 8 is 0 are discarded, and characters whose bit 8 is 1 are stored.
- R9: `rts_ready` is 0 whenever the queue holds 3 or more words, and 1 otherwise.
- R10: With `cfg_loopback`=1 the receiver samples `lb_tx_i`, and `rx_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | External serial line, idle high |
| lb_tx_i | input | 1 | Local transmit line used in loopback |
| cfg_loopback | input | 1 | 1 = receive from `lb_tx_i` |
| cfg_nine_bit | input | 1 | 1 = 9 data bits |
| cfg_parity | input | 2 | 00 none, 01 even, 10 odd (8-bit mode only) |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_quad | input | 1 | 1 = 4 samples per bit, 0 = 16 |
| cfg_div | input | 16 | Sample tick every `cfg_div`+1 clocks |
| cfg_addr_en | input | 1 | Address filter in 9-bit mode |
| rd_en | input | 1 | Pop oldest word |
| ovf_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 9 | Oldest word |
| rd_perr | output | 1 | Parity error of oldest word |
| rd_ferr | output | 1 | Framing error of oldest word |
| not_empty | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Sticky overrun flag |
| rts_ready | output | 1 | Flow control: 1 = far end may send |

## Verification
A state machine that fell out of step with the bit boundaries would sample neighbouring bits. The corruption would show as shifted data or false parity and framing flags on the very next word read from the queue. A queue pointer or count error would show as reordered or repeated words, or as `rts_ready`/`not_empty` disagreeing with the number of words sent and read, within the next push or pop. A wrongly held or released overrun flag would show as a word stored after an overflow, or one lost after the clear, within one character time.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [8:0] data;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    localparam logic [1:0] PAR_NONE = 2'b00;
    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic lb_i,
    input  logic lb_en,
    output logic line_o
);
    logic [STAGES-1:0] sync_q;
    logic              raw;

    assign raw = lb_en ? lb_i : rx_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], raw};
    end

    assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       hold,
    input  logic       cfg_nine_bit,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    input  logic       cfg_quad,
    input  logic       cfg_addr_en,
    output logic       word_vld,
    output rx_word_t   word
);
    rx_state_e  state_q, state_d;
    logic [3:0] cnt_q, cnt_d;
    logic [3:0] idx_q, idx_d;
    logic [8:0] data_q, data_d;
    logic       par_q, par_d;
    logic [3:0] os_last, half_last, bit_last;
    logic       par_on, at_centre, exp_par;

    assign os_last   = cfg_quad ? 4'd3 : 4'd15;
    assign half_last = cfg_quad ? 4'd1 : 4'd7;
    assign bit_last  = cfg_nine_bit ? 4'd8 : 4'd7;
    assign par_on    = !cfg_nine_bit && (cfg_parity != PAR_NONE);
    assign at_centre = tick && (cnt_q == os_last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            data_q  <= data_d;
            par_q   <= par_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        data_d  = data_q;
        par_d   = par_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !hold && !line) begin
                    state_d = ST_START;
                    cnt_d   = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cnt_q == half_last) begin
                        cnt_d  = '0;
                        idx_d  = '0;
                        data_d = '0;
                        state_d = line ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (at_centre) begin
                    cnt_d = '0;
                    data_d[idx_q] = line;
                    if (idx_q == bit_last) state_d = par_on ? ST_PARITY : ST_STOP1;
                    else                   idx_d = idx_q + 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PARITY: begin
                if (at_centre) begin
                    cnt_d   = '0;
                    par_d   = line;
                    state_d = ST_STOP1;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STOP1: begin
                if (at_centre) begin
                    cnt_d   = '0;
                    state_d = cfg_two_stop ? ST_STOP2 : ST_IDLE;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STOP2: begin
                if (at_centre)   state_d = ST_IDLE;
                else if (tick)   cnt_d = cnt_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        exp_par    = (^data_q[7:0]) ^ (cfg_parity == PAR_ODD);
        word.data  = {cfg_nine_bit & data_q[8], data_q[7:0]};
        word.perr  = par_on && (par_q != exp_par);
        word.ferr  = !line;
        word_vld   = (state_q == ST_STOP1) && at_centre &&
                     !(cfg_nine_bit && cfg_addr_en && !data_q[8]);
    end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt_q != '0);
    assign dout    = mem_q[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wp_q] <= din;
                wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
    import uart_rx_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DEPTH     = 4,
    parameter int RTS_LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             lb_tx_i,
    input  logic             cfg_loopback,
    input  logic             cfg_nine_bit,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_two_stop,
    input  logic             cfg_quad,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_addr_en,
    input  logic             rd_en,
    input  logic             ovf_clr,
    output logic [8:0]       rd_data,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             not_empty,
    output logic             overrun,
    output logic             rts_ready
);
    localparam int WW = $bits(rx_word_t);
    localparam int CW = $clog2(DEPTH+1);

    logic          line, tick, word_vld, q_full, ovf_q;
    rx_word_t      word, head;
    logic [CW-1:0] q_count;

    rx_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .lb_i(lb_tx_i),
        .lb_en(cfg_loopback), .line_o(line)
    );

    rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
    );

    rx_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line), .hold(ovf_q),
        .cfg_nine_bit(cfg_nine_bit), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .cfg_quad(cfg_quad),
        .cfg_addr_en(cfg_addr_en), .word_vld(word_vld), .word(word)
    );

    rx_word_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(word_vld), .din(word),
        .pop(rd_en), .dout(head), .count(q_count), .full(q_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ovf_q <= 1'b0;
        else if (word_vld && q_full) ovf_q <= 1'b1;
        else if (ovf_clr)          ovf_q <= 1'b0;
    end

    assign rd_data   = head.data;
    assign rd_perr   = head.perr;
    assign rd_ferr   = head.ferr;
    assign not_empty = (q_count != '0);
    assign overrun   = ovf_q;
    assign rts_ready = (q_count < CW'(RTS_LEVEL));
endmodule

// File: rtl/uart_rx_addr_chk.sv
module uart_rx_addr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       ovf_clr,
    input logic [8:0] rd_data,
    input logic       not_empty,
    input logic       overrun,
    input logic       rts_ready,
    input logic       cfg_nine_bit,
    input logic       cfg_addr_en,
    input logic       word_vld,
    input logic [8:0] word_data
);
    a_r9_rts_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> rts_ready);

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovf_clr) |=> overrun);

    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !word_vld) |=> !overrun);

    a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && !rd_en) |=> (not_empty && $stable(rd_data)));

    a_r8_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && cfg_nine_bit && cfg_addr_en) |-> word_data[8]);

    a_r7_no_rx_in_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && $past(overrun)) |-> !word_vld);
endmodule

bind uart_rx_addr uart_rx_addr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .not_empty(not_empty), .overrun(overrun),
    .rts_ready(rts_ready), .cfg_nine_bit(cfg_nine_bit),
    .cfg_addr_en(cfg_addr_en), .word_vld(word_vld), .word_data(word.data)
);

// File: tb/uart_rx_addr_tb_top.sv
module uart_rx_addr_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        rx_i = 1, lb_tx_i = 1;
    logic        cfg_loopback = 0, cfg_nine_bit = 0, cfg_two_stop = 0, cfg_quad = 0, cfg_addr_en = 0;
    logic [1:0]  cfg_parity = 0;
    logic [15:0] cfg_div = 1;
    logic        rd_en = 0, ovf_clr = 0;
    logic [8:0]  rd_data;
    logic        rd_perr, rd_ferr, not_empty, overrun, rts_ready;
    int          n_tests = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    uart_rx_addr dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .lb_tx_i(lb_tx_i),
        .cfg_loopback(cfg_loopback), .cfg_nine_bit(cfg_nine_bit),
        .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .cfg_quad(cfg_quad),
        .cfg_div(cfg_div), .cfg_addr_en(cfg_addr_en), .rd_en(rd_en),
        .ovf_clr(ovf_clr), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .not_empty(not_empty), .overrun(overrun), .rts_ready(rts_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_time();
        return (int'(cfg_div) + 1) * (cfg_quad ? 4 : 16);
    endfunction

    function automatic logic par_bit(input logic [8:0] w);
        return (^w[7:0]) ^ (cfg_parity == 2'b10);
    endfunction

    function automatic logic [8:0] exp_data(input logic [8:0] w);
        return cfg_nine_bit ? w : {1'b0, w[7:0]};
    endfunction

    task automatic drive(input logic v, input int n);
        if (cfg_loopback) lb_tx_i = v; else rx_i = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] w, input bit bad_par, input bit bad_stop);
        int bt = bit_time();
        drive(1'b0, bt);
        for (int i = 0; i < (cfg_nine_bit ? 9 : 8); i++) drive(w[i], bt);
        if (!cfg_nine_bit && cfg_parity != 2'b00) drive(par_bit(w) ^ bad_par, bt);
        if (bad_stop) begin
            drive(1'b0, bt * 3 / 4);
            drive(1'b1, bt - bt * 3 / 4);
        end else drive(1'b1, bt);
        if (cfg_two_stop) drive(1'b1, bt);
        drive(1'b1, 2 * bt);
    endtask

    task automatic pop_check(input string tag, input logic [8:0] d, input logic pe, input logic fe);
        check(not_empty === 1'b1, {tag, " not_empty"}, not_empty, 1);
        check(rd_data === d, {tag, " data"}, rd_data, d);
        check(rd_perr === pe, {tag, " perr"}, rd_perr, pe);
        check(rd_ferr === fe, {tag, " ferr"}, rd_ferr, fe);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] w;
        bit bp, bs;
        void'($urandom(32'h1234_5a5a));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(not_empty === 0, "R1 not_empty", not_empty, 0);
        check(overrun === 0, "R1 overrun", overrun, 0);
        check(rts_ready === 1, "R1 rts_ready", rts_ready, 1);

        // R3 short glitch
        rx_i = 0;
        repeat (bit_time() / 4) @(negedge clk);
        rx_i = 1;
        repeat (3 * bit_time()) @(negedge clk);
        check(not_empty === 0, "R3 glitch ignored", not_empty, 0);

        // R2 R4 R5 constrained random frames
        for (int k = 0; k < 30; k++) begin
            cfg_div      = 16'($urandom_range(0, 2));
            cfg_quad     = 1'($urandom_range(0, 1));
            cfg_nine_bit = 1'($urandom_range(0, 1));
            cfg_parity   = 2'($urandom_range(0, 2));
            cfg_two_stop = 1'($urandom_range(0, 1));
            w  = 9'($urandom);
            bp = ($urandom_range(0, 3) == 0);
            bs = ($urandom_range(0, 4) == 0);
            repeat (2 * bit_time()) @(negedge clk);
            send(w, bp, bs);
            pop_check("R2 R4 R5 random", exp_data(w),
                      bp && !cfg_nine_bit && cfg_parity != 2'b00, bs);
            check(not_empty === 0, "R6 empty after pop", not_empty, 0);
        end

        // directed: 4x mode even parity, all ones
        cfg_div = 0; cfg_quad = 1; cfg_nine_bit = 0; cfg_parity = 2'b01; cfg_two_stop = 0;
        repeat (8) @(negedge clk);
        send(9'h0FF, 1'b0, 1'b0);
        pop_check("R2 R4 quad even", 9'h0FF, 0, 0);
        // R4 odd parity error
        cfg_parity = 2'b10;
        send(9'h000, 1'b1, 1'b0);
        pop_check("R4 odd perr", 9'h000, 1, 0);

        // R8 address filter
        cfg_div = 1; cfg_quad = 0; cfg_nine_bit = 1; cfg_addr_en = 1;
        repeat (40) @(negedge clk);
        send(9'h055, 1'b0, 1'b0);
        check(not_empty === 0, "R8 data char dropped", not_empty, 0);
        send(9'h1A3, 1'b0, 1'b0);
        pop_check("R8 address char kept", 9'h1A3, 0, 0);
        cfg_addr_en = 0;
        send(9'h055, 1'b0, 1'b0);
        pop_check("R8 filter off", 9'h055, 0, 0);

        // R10 loopback, rx_i held low and ignored
        cfg_nine_bit = 0; cfg_parity = 2'b00;
        rx_i = 0; cfg_loopback = 1;
        repeat (40) @(negedge clk);
        send(9'h03C, 1'b0, 1'b0);
        pop_check("R10 loopback", 9'h03C, 0, 0);
        check(not_empty === 0, "R10 rx_i ignored", not_empty, 0);
        rx_i = 1;
        repeat (40) @(negedge clk);
        cfg_loopback = 0;
        repeat (80) @(negedge clk);

        // R6 R7 R9 fill and overflow
        for (int k = 1; k <= 4; k++) begin
            send(9'(k * 17), 1'b0, 1'b0);
            check(rts_ready === (k < 3), "R9 rts_ready", rts_ready, int'(k < 3));
        end
        check(overrun === 0, "R7 no overrun at full", overrun, 0);
        send(9'h0E5, 1'b0, 1'b0);
        check(overrun === 1, "R7 overrun set", overrun, 1);
        rd_en = 1; @(negedge clk); rd_en = 0;
        send(9'h0E6, 1'b0, 1'b0);
        check(overrun === 1, "R7 overrun sticky", overrun, 1);
        ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        check(overrun === 0, "R7 overrun cleared", overrun, 0);
        for (int k = 2; k <= 4; k++) pop_check("R6 order", 9'(k * 17), 0, 0);
        check(not_empty === 0, "R7 held chars dropped", not_empty, 0);
        send(9'h0E7, 1'b0, 1'b0);
        pop_check("R7 resume after clear", 9'h0E7, 0, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule